// File: doc/BRIEF.md
# Video-Address Edge Scanline Interrupt Counter

This block sits on the cartridge side of a game system. It counts rising edges of one video address line, bit 12, and raises an interrupt when a programmed number of edges has passed. During normal rendering that line rises once per scanline, so the count is a number of scanlines. Edges caused by the CPU writing the video address also count, because the block sees only the sampled bit.

The CPU sets the block up through a small write port with four registers:

| `wr_sel` | Register | Effect of a write |
|---|---|---|
| 0 | latch | stores the reload value from `wr_data` |
| 1 | reload | asks for the counter to be refilled on the next counting edge |
| 2 | disable/ack | clears a pending interrupt and turns interrupts off |
| 3 | enable | turns interrupts on |

A write completes in the cycle it is presented; there is no back-pressure. The interrupt output is a level. It stays high until software writes the disable/acknowledge register; the CPU taking the interrupt does not clear it.

The input `zero_rule_alt` picks one of two silicon revisions of the zero rule:

- With `zero_rule_alt` low, the interrupt fires only when the counter steps down from 1 to 0.
- With `zero_rule_alt` high, the interrupt fires whenever the counter holds 0 after an edge, including a refill to 0.

Top module: `scanline_irq_counter`

## Requirements
- R1: The counter is clocked only in a cycle where `vaddr_a12` is 1 and its value in the previous cycle was 0. A level held high, or a falling transition, does not clock it. The stored previous value is 0 after reset.
- R2: On a clock, if the counter is 0 or the reload request is set, the counter takes the latch value and the request is cleared. Otherwise the counter decreases by 1.
- R3: A latch write (`wr_sel`=0) stores `wr_data` and leaves the current count untouched. A reload write (`wr_sel`=1) only sets the reload request. If a reload write coincides with a clock, the request stays set afterwards.
- R4: With `zero_rule_alt`=0, `irq` rises one cycle after a clock that moves the counter from 1 to 0 while enabled. With latch N≥1, the first interrupt after a reload comes on the (N+1)th edge. With latch 0 it never comes.
- R5: With `zero_rule_alt`=1, `irq` rises after any clock that leaves the counter at 0 while enabled. This includes a refill from a latch of 0, which then fires on every edge.
- R6: A disable/ack write (`wr_sel`=2) drives `irq` low on the next cycle and clears the enable. It wins over a simultaneous trigger.
- R7: Once high, `irq` stays high across further edges and other writes until a disable/ack write.
- R8: An enable write (`wr_sel`=3) sets the enable. While the enable is clear, reaching 0 does not raise `irq`. Reset leaves `irq` low, the enable clear and the counter, latch and request at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU register write strobe |
| wr_sel | input | 2 | Register select: 0 latch, 1 reload, 2 disable/ack, 3 enable |
| wr_data | input | 8 | Write data (used by the latch write) |
| vaddr_a12 | input | 1 | Sampled video address bit 12 |
| zero_rule_alt | input | 1 | Zero-rule revision select (0 decrement-only, 1 any zero) |
| irq | output | 1 | Level interrupt request |

## Verification
The main function is tried with several kinds of stimulus:

- Clean one-cycle pulses on the address bit, with latches of 4, 2 and 0. These show the N+1 edge count and the refill-from-zero path.
- A pulse held high over several cycles. This separates edge counting from level counting.
- Latch 0 in both revisions. This tells the decrement-only rule from the any-zero rule.
- Counting to zero with interrupts disabled, and rewriting the latch mid-count. These show that the enable gates only the output and that a latch write does not touch the running count.
- Edges and writes after the interrupt has fired. These show that the output is a held level cleared only by the acknowledge write.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
  typedef enum logic [1:0] {
    SEL_LATCH   = 2'd0,
    SEL_RELOAD  = 2'd1,
    SEL_DISABLE = 2'd2,
    SEL_ENABLE  = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/a12_edge_detect.sv
module a12_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= line_in;
  end

  assign rise = line_in & ~prev_q;

  // R1
  rise_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/scanline_down_counter.sv
module scanline_down_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             latch_wr,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] latch_data,
  input  logic             zero_rule_alt,
  output logic             fire
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] latch_q, cnt_q, cnt_d;
  logic             reload_q, refill;

  assign refill = (cnt_q == ZERO) || reload_q;
  assign cnt_d  = refill ? latch_q : cnt_q - ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q  <= ZERO;
      cnt_q    <= ZERO;
      reload_q <= 1'b0;
    end else begin
      if (latch_wr) latch_q <= latch_data;
      if (tick)     cnt_q   <= cnt_d;
      if (reload_wr)  reload_q <= 1'b1;
      else if (tick)  reload_q <= 1'b0;
    end
  end

  assign fire = tick && (cnt_d == ZERO) && (zero_rule_alt || (cnt_q == ONE));

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(cnt_q));
  // R2
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick) && $past(cnt_q) != ZERO && !$past(reload_q)) |-> cnt_q == $past(cnt_q) - ONE);
  // R2
  reload_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !reload_wr) |=> !reload_q);
  // R3
  reload_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_wr |=> reload_q);
endmodule

// File: rtl/irq_level_ctl.sv
module irq_level_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic dis_wr,
  input  logic en_wr,
  output logic irq
);
  logic en_q, irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (dis_wr) begin
        en_q  <= 1'b0;
        irq_q <= 1'b0;
      end else begin
        if (en_wr)        en_q  <= 1'b1;
        if (fire && en_q) irq_q <= 1'b1;
      end
    end
  end

  assign irq = irq_q;

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr |=> !irq);
  // R7
  irq_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !dis_wr) |=> irq);
  // R8
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(en_q));
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             vaddr_a12,
  input  logic             zero_rule_alt,
  output logic             irq
);
  import scanline_irq_pkg::*;

  logic tick, fire;
  logic latch_wr, reload_wr, dis_wr, en_wr;

  assign latch_wr  = wr_en && (wr_sel == SEL_LATCH);
  assign reload_wr = wr_en && (wr_sel == SEL_RELOAD);
  assign dis_wr    = wr_en && (wr_sel == SEL_DISABLE);
  assign en_wr     = wr_en && (wr_sel == SEL_ENABLE);

  a12_edge_detect edge_i (
    .clk(clk), .rst_n(rst_n), .line_in(vaddr_a12), .rise(tick)
  );

  scanline_down_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .latch_wr(latch_wr),
    .reload_wr(reload_wr), .latch_data(wr_data),
    .zero_rule_alt(zero_rule_alt), .fire(fire)
  );

  irq_level_ctl irq_i (
    .clk(clk), .rst_n(rst_n), .fire(fire), .dis_wr(dis_wr),
    .en_wr(en_wr), .irq(irq)
  );

  // R4
  irq_rise_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick));
endmodule

// File: tb/scanline_irq_counter_tb.sv
module scanline_irq_counter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       a12 = 1'b0;
  logic       alt = 1'b0;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R8";

  // behavioural reference state
  int m_latch = 0, m_cnt = 0, m_prev = 0;
  bit m_rel = 0, m_en = 0, m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scanline_irq_counter dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .vaddr_a12(a12), .zero_rule_alt(alt), .irq(irq)
  );

  task automatic check(input string req, input bit act, input bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: irq=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit tk, fire;
    int old;
    tk = rst_n && a12 && (m_prev == 0);
    fire = 0;
    if (!rst_n) begin
      m_latch = 0; m_cnt = 0; m_rel = 0; m_en = 0; m_irq = 0; m_prev = 0;
      return;
    end
    if (tk) begin
      old = m_cnt;
      if (m_cnt == 0 || m_rel) begin m_cnt = m_latch; m_rel = 0; end
      else m_cnt = m_cnt - 1;
      fire = (m_cnt == 0) && m_en && (alt || old == 1);
    end
    m_prev = a12;
    if (wr_en) begin
      case (wr_sel)
        2'd0: m_latch = wr_data;
        2'd1: m_rel = 1;
        2'd2: begin m_en = 0; m_irq = 0; end
        default: m_en = 1;
      endcase
    end
    if (!(wr_en && wr_sel == 2'd2) && fire) m_irq = 1;
  endtask

  // one cycle: inputs already set at negedge; model at posedge; compare at next negedge
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    wr_en = 1'b0;
    check(cur_req, irq, m_irq);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    cyc();
  endtask

  task automatic edge_pulse();
    a12 = 1'b1; cyc();
    a12 = 1'b0; cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: irq=%0b expected run end", irq);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    cur_req = "R8";
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    check("R8 reset", irq, 1'b0);

    // R4: latch 4, decrement-only rule -> first IRQ on 5th edge
    cur_req = "R4";
    wr(2'd0, 8'd4); wr(2'd1, 8'd0); wr(2'd3, 8'd0);
    for (int i = 1; i <= 4; i++) begin
      edge_pulse();
      check("R4 before N+1", irq, 1'b0);
    end
    edge_pulse();
    check("R4 edge N+1", irq, 1'b1);

    // R7: stays high across edges and other writes
    cur_req = "R7";
    for (int i = 0; i < 6; i++) edge_pulse();
    wr(2'd0, 8'd7); wr(2'd3, 8'd0);
    check("R7 held", irq, 1'b1);

    // R6: ack clears
    cur_req = "R6";
    wr(2'd2, 8'd0);
    check("R6 ack", irq, 1'b0);

    // R1: long high level counts once
    cur_req = "R1";
    wr(2'd0, 8'd2); wr(2'd1, 8'd0); wr(2'd3, 8'd0);
    edge_pulse();                 // refill to 2
    a12 = 1'b1;
    for (int i = 0; i < 6; i++) cyc(); // -> 1 once
    a12 = 1'b0; cyc(); cyc();
    check("R1 held level", irq, 1'b0);
    edge_pulse();                 // -> 0 fires
    check("R1 next edge", irq, 1'b1);
    wr(2'd2, 8'd0);

    // R2: after zero, next edge refills from latch 2 -> fires 3 edges later
    cur_req = "R2";
    wr(2'd3, 8'd0);
    edge_pulse(); edge_pulse();
    check("R2 refill", irq, 1'b0);
    edge_pulse();
    check("R2 decrement to zero", irq, 1'b1);
    wr(2'd2, 8'd0);

    // R4: latch 0, decrement-only rule never fires
    cur_req = "R4";
    wr(2'd0, 8'd0); wr(2'd1, 8'd0); wr(2'd3, 8'd0);
    for (int i = 0; i < 5; i++) edge_pulse();
    check("R4 latch0 silent", irq, 1'b0);

    // R5: any-zero rule fires on refill to 0
    cur_req = "R5";
    alt = 1'b1;
    edge_pulse();
    check("R5 latch0 fires", irq, 1'b1);
    wr(2'd2, 8'd0); wr(2'd3, 8'd0);
    edge_pulse();
    check("R5 every edge", irq, 1'b1);
    wr(2'd2, 8'd0);
    alt = 1'b0;

    // R8 + R3: disabled count reaches 0 silently; latch write leaves count alone
    cur_req = "R3";
    wr(2'd0, 8'd3); wr(2'd1, 8'd0);
    edge_pulse();                 // 3
    wr(2'd0, 8'd9);
    edge_pulse(); edge_pulse();   // 2, 1
    wr(2'd3, 8'd0);
    edge_pulse();                 // 0
    check("R3 latch write kept count", irq, 1'b1);
    wr(2'd2, 8'd0);
    cur_req = "R8";
    wr(2'd0, 8'd1); wr(2'd1, 8'd0);
    edge_pulse(); edge_pulse();   // 1, 0 while disabled
    check("R8 disabled no irq", irq, 1'b0);

    // R3: reload write coinciding with an edge keeps request
    cur_req = "R3";
    wr(2'd0, 8'd2); wr(2'd3, 8'd0);
    a12 = 1'b1; wr(2'd1, 8'd0); a12 = 1'b0; cyc();
    edge_pulse();                 // refill again to 2
    edge_pulse();                 // 1
    check("R3 coincident reload", irq, 1'b0);
    edge_pulse();                 // 0
    check("R3 coincident reload fire", irq, 1'b1);
    wr(2'd2, 8'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule